// File: doc/BRIEF.md
# SPI Host Controller with Register Access

This block is a memory-mapped SPI host. Software writes a serial clock divisor, a clock polarity and phase, a frame width and a select index through a small 32-bit register bus. Writing the transmit register while the block is idle sends one frame. The frame is sent most significant bit first, with one active-low select line held low for the whole frame.

The word shifted in on the data-input line is kept in a receive register until the next frame completes. A busy flag shows that a frame is in flight. A sticky completion bit, mirrored on an interrupt output, marks the end of each frame.

The serial clock divisor has two encodings, chosen by the static parameter `DIV_MODE`. Mode 0 is an even-divisor code. Mode 1 is a two-stage code: a linear factor multiplied by a power of two.

Top module: `spi_host_ctrl`

## Requirements
- R1: Register offsets are: control 0x00, configuration 0x04, transmit 0x08, receive 0x0C, completion status 0x10, sample timing 0x18. A read returns its data on `bus_rdata` one clock after `bus_rd`.
  - Control holds the select index in bits [4:2].
  - Configuration keeps bits 12 (phase), 11 (polarity) and 5 (width). It also keeps the divisor bits under mask 0x1F in mode 0 or 0xDF in mode 1. Reading all-ones written gives 0x183F in mode 0 and 0x18FF in mode 1.
  - Sample timing keeps bits [7:6]; they have no other effect.
- R2: While idle, every bit of `cs_n` is 1. During a frame, exactly bit `idx` is 0 for the whole frame, where `idx` is the select index latched when the frame starts.
- R3: A transmit write while idle starts a frame. The frame shifts the write's low 16 bits (configuration bit 5 = 1) or low 8 bits (bit 5 = 0) out on `mosi`, most significant bit first.
- R4: At frame end, the receive register takes the bits sampled from `miso`, first bit most significant, right-aligned with zeros above. It holds them until the next frame ends.
- R5: Between frames `sclk` rests at the polarity bit. A frame has exactly 2 edges per bit.
  - Phase 0: data is sampled on the odd-numbered edges.
  - Phase 1: data is sampled on the even-numbered edges.
- R6: Mode 0: the divisor D is 2*N, where N is divisor bits [3:0]. N below 2 counts as 2.
- R7: Mode 1: D = spr << sppr.
  - spr is bits [3:0], and 0 counts as 1.
  - sppr is {bit 7, bit 6, bit 4}.
  - A result below 2 counts as 2.
- R8: Control bit 1 reads 1 while a frame is in flight and 0 otherwise.
- R9: Completion bit 0 sets when a frame ends. Writing 1 to it clears it; writing 0 leaves it. `irq` equals this bit.
- R10: A transmit write while busy is ignored. The frame in flight and the transmit readback are unchanged, and no further frame follows.
- R11: The first `sclk` edge comes D - floor(D/2) clocks after the select goes low. The edge pattern repeats every D clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low selects |
| irq | output | 1 | Completion flag |

## Verification
The bench builds two copies with the default 8 selects and 16-bit frames: one with `DIV_MODE` = 1 and one with `DIV_MODE` = 0. Both copies receive the same bus writes, and the checks are made on one copy at a time.

The sweep crosses all four polarity/phase settings with both frame widths and five divisor codes per mode. The codes include the clamped ones and an odd two-stage divisor, so the uneven split of a clock period and every select line come within reach.

Divisors, first-edge delays, serial bit order and received words are computed arithmetically and compared with what a bench-side serial target observes.

// File: rtl/spih_pkg.sv
package spih_pkg;
  localparam int REG_AW  = 5;
  localparam int DATA_W  = 32;
  localparam int PER_W   = 11;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_CFG   = 5'h04;
  localparam logic [REG_AW-1:0] OFS_TX    = 5'h08;
  localparam logic [REG_AW-1:0] OFS_RX    = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CAUSE = 5'h10;
  localparam logic [REG_AW-1:0] OFS_TIME  = 5'h18;
  localparam int CFG_W      = 13;
  localparam int CFG_WIDE   = 5;
  localparam int CFG_CPOL   = 11;
  localparam int CFG_CPHA   = 12;
endpackage

// File: rtl/spih_clkdiv.sv
module spih_clkdiv #(
  parameter int DIV_MODE = 1,
  parameter int PER_W    = 11
) (
  input  logic [7:0]       code,
  output logic [PER_W-1:0] period
);
  generate
    if (DIV_MODE == 0) begin : g_even
      logic [3:0] n_cl;
      logic       unused_code;
      assign unused_code = ^code[7:4];
      always_comb begin
        n_cl   = (code[3:0] < 4'd2) ? 4'd2 : code[3:0];
        period = PER_W'({n_cl, 1'b0});
      end
    end else begin : g_split
      logic [3:0]       lin;
      logic [2:0]       expo;
      logic [PER_W-1:0] raw;
      logic             unused_code;
      assign unused_code = code[5];
      always_comb begin
        lin    = (code[3:0] == 4'd0) ? 4'd1 : code[3:0];
        expo   = {code[7:6], code[4]};
        raw    = PER_W'(lin) << expo;
        period = (raw < PER_W'(2)) ? PER_W'(2) : raw;
      end
    end
  endgenerate
endmodule

// File: rtl/spih_engine.sv
module spih_engine #(
  parameter int NUM_CS  = 8,
  parameter int CS_W    = 3,
  parameter int FRAME_W = 16,
  parameter int PER_W   = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [CS_W-1:0]    cs_idx,
  input  logic [PER_W-1:0]   period,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               wide,
  input  logic               miso,
  output logic               busy,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_CS-1:0]  cs_n,
  output logic               done,
  output logic [FRAME_W-1:0] rx_word
);
  localparam int HALF_W = FRAME_W / 2;
  localparam int EDGE_W = $clog2(2 * FRAME_W + 1);

  logic               busy_q, sclk_q, done_q;
  logic [NUM_CS-1:0]  cs_q;
  logic [FRAME_W-1:0] tx_sr, rx_sr, rx_nxt, rx_word_q;
  logic [EDGE_W-1:0]  edge_q, edge_nxt, last_edge;
  logic [PER_W-1:0]   per_q, cnt_q, lead_len, trail_len, cur_len;
  logic               cpol_q, cpha_q, wide_q;
  logic               at_edge, lead_edge, do_sample, do_shift;

  assign lead_len  = per_q - (per_q >> 1);
  assign trail_len = per_q >> 1;
  assign cur_len   = edge_q[0] ? trail_len : lead_len;
  assign at_edge   = busy_q && (cnt_q == cur_len - 1'b1);
  assign edge_nxt  = edge_q + 1'b1;
  assign lead_edge = edge_nxt[0];
  assign do_sample = cpha_q ? !lead_edge : lead_edge;
  assign do_shift  = cpha_q ? (lead_edge && edge_nxt != EDGE_W'(1)) : !lead_edge;
  assign last_edge = wide_q ? EDGE_W'(2 * FRAME_W) : EDGE_W'(FRAME_W);
  assign rx_nxt    = do_sample ? {rx_sr[FRAME_W-2:0], miso} : rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      sclk_q    <= 1'b0;
      cs_q      <= '1;
      tx_sr     <= '0;
      rx_sr     <= '0;
      rx_word_q <= '0;
      edge_q    <= '0;
      cnt_q     <= '0;
      per_q     <= PER_W'(2);
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      wide_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        sclk_q <= cpol;
        if (start) begin
          busy_q <= 1'b1;
          cs_q   <= ~(NUM_CS'(1) << cs_idx);
          tx_sr  <= wide ? tx_word : {tx_word[HALF_W-1:0], HALF_W'(0)};
          rx_sr  <= '0;
          edge_q <= '0;
          cnt_q  <= '0;
          per_q  <= period;
          cpol_q <= cpol;
          cpha_q <= cpha;
          wide_q <= wide;
        end
      end else if (at_edge) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
        edge_q <= edge_nxt;
        rx_sr  <= rx_nxt;
        if (do_shift) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
        if (edge_nxt == last_edge) begin
          busy_q    <= 1'b0;
          cs_q      <= '1;
          done_q    <= 1'b1;
          rx_word_q <= wide_q ? rx_nxt : {HALF_W'(0), rx_nxt[HALF_W-1:0]};
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_sr[FRAME_W-1];
  assign cs_n    = cs_q;
  assign done    = done_q;
  assign rx_word = rx_word_q;

  a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_q));
  a_r2_idle_release: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (cs_q == '1));
  a_r5_end_level: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (sclk_q == cpol_q));
  a_r8_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spih_pkg::*;
#(
  parameter int DIV_MODE = 1,
  parameter int NUM_CS   = 8,
  parameter int FRAME_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              irq
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam logic [CFG_W-1:0] CFG_MASK = (DIV_MODE == 0) ? 13'h183F : 13'h18FF;

  logic [CS_W-1:0]    cs_idx_q;
  logic [CFG_W-1:0]   cfg_q;
  logic [FRAME_W-1:0] tx_q, rx_q, eng_rx;
  logic [1:0]         smpl_q;
  logic               cause_q;
  logic [DATA_W-1:0]  rdata_q, rd_mux;
  logic [PER_W-1:0]   period;
  logic               eng_busy, eng_done, start;
  logic               wr_ctrl, wr_cfg, wr_tx, wr_cause, wr_time;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata[31:CFG_W];
  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_cfg   = bus_wr && (bus_addr == OFS_CFG);
  assign wr_tx    = bus_wr && (bus_addr == OFS_TX);
  assign wr_cause = bus_wr && (bus_addr == OFS_CAUSE);
  assign wr_time  = bus_wr && (bus_addr == OFS_TIME);
  assign start    = wr_tx && !eng_busy;

  spih_clkdiv #(.DIV_MODE(DIV_MODE), .PER_W(PER_W)) u_clkdiv (
    .code   (cfg_q[7:0]),
    .period (period)
  );

  spih_engine #(.NUM_CS(NUM_CS), .CS_W(CS_W), .FRAME_W(FRAME_W), .PER_W(PER_W)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .tx_word (bus_wdata[FRAME_W-1:0]),
    .cs_idx  (cs_idx_q),
    .period  (period),
    .cpol    (cfg_q[CFG_CPOL]),
    .cpha    (cfg_q[CFG_CPHA]),
    .wide    (cfg_q[CFG_WIDE]),
    .miso    (miso),
    .busy    (eng_busy),
    .sclk    (sclk),
    .mosi    (mosi),
    .cs_n    (cs_n),
    .done    (eng_done),
    .rx_word (eng_rx)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_CTRL: begin
        rd_mux[2 +: CS_W] = cs_idx_q;
        rd_mux[1]         = eng_busy;
      end
      OFS_CFG:   rd_mux[CFG_W-1:0]   = cfg_q;
      OFS_TX:    rd_mux[FRAME_W-1:0] = tx_q;
      OFS_RX:    rd_mux[FRAME_W-1:0] = rx_q;
      OFS_CAUSE: rd_mux[0]           = cause_q;
      OFS_TIME:  rd_mux[7:6]         = smpl_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_idx_q <= '0;
      cfg_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      smpl_q   <= '0;
      cause_q  <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_ctrl) cs_idx_q <= bus_wdata[2 +: CS_W];
      if (wr_cfg)  cfg_q    <= bus_wdata[CFG_W-1:0] & CFG_MASK;
      if (start)   tx_q     <= bus_wdata[FRAME_W-1:0];
      if (wr_time) smpl_q   <= bus_wdata[7:6];
      if (eng_done) rx_q    <= eng_rx;
      if (eng_done) cause_q <= 1'b1;
      else if (wr_cause && bus_wdata[0]) cause_q <= 1'b0;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = cause_q;

  a_r10_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_tx && eng_busy) |=> $stable(tx_q));
  a_r9_cause_source: assert property (@(posedge clk) disable iff (rst)
    $rose(cause_q) |-> $past(eng_done));
  a_r4_rx_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(eng_done) |-> $stable(rx_q));
endmodule

// File: tb/spi_host_ctrl_bench.sv
module spi_host_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  b_addr = '0;
  logic        b_wr = 1'b0, b_rd = 1'b0;
  logic [31:0] b_wdata = '0;
  logic [31:0] rdata_s, rdata_e;
  logic        sclk_s, sclk_e, mosi_s, mosi_e, irq_s, irq_e, miso;
  logic [7:0]  cs_s, cs_e;

  int nchk = 0, nfail = 0;
  int sel = 1;
  int m_cpha = 0, nbits = 8, ncnt = 0, fcount = 0;
  int edges = 0, idx = 0, t_start = 0, t_e1 = 0, t_e3 = 0;
  logic [15:0] slave_word = '0, cap = '0;
  logic [7:0]  cs_seen = '1, prev_cs = '1;
  logic        cs_bad = 1'b0, prev_sclk = 1'b0, lvl_start = 1'b0;

  always #10 clk = ~clk;

  spi_host_ctrl #(.DIV_MODE(1)) u_spi_host_ctrl (
    .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_wr(b_wr), .bus_wdata(b_wdata),
    .bus_rd(b_rd), .bus_rdata(rdata_s), .sclk(sclk_s), .mosi(mosi_s), .miso(miso),
    .cs_n(cs_s), .irq(irq_s));
  spi_host_ctrl #(.DIV_MODE(0)) u_spi_host_ctrl_even (
    .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_wr(b_wr), .bus_wdata(b_wdata),
    .bus_rd(b_rd), .bus_rdata(rdata_e), .sclk(sclk_e), .mosi(mosi_e), .miso(miso),
    .cs_n(cs_e), .irq(irq_e));

  wire       s_sclk = sel ? sclk_s : sclk_e;
  wire       s_mosi = sel ? mosi_s : mosi_e;
  wire [7:0] s_cs   = sel ? cs_s : cs_e;
  wire       s_irq  = sel ? irq_s : irq_e;

  assign miso = (idx < nbits) ? slave_word[nbits-1-idx] : 1'b0;

  // serial target model, observes the selected copy away from the active edge
  always @(negedge clk) begin
    ncnt = ncnt + 1;
    if (prev_cs == 8'hFF && s_cs != 8'hFF) begin
      t_start = ncnt; edges = 0; idx = 0; cap = '0;
      cs_seen = s_cs; cs_bad = 1'b0; lvl_start = prev_sclk;
    end
    if (prev_cs != 8'hFF) begin
      if (s_cs != 8'hFF && s_cs != cs_seen) cs_bad = 1'b1;
      if (s_sclk != prev_sclk) begin
        edges = edges + 1;
        if (edges == 1) t_e1 = ncnt;
        if (edges == 3) t_e3 = ncnt;
        if (((edges % 2) == 1) != (m_cpha == 1)) begin
          cap = {cap[14:0], s_mosi};
          idx = idx + 1;
        end
      end
      if (s_cs == 8'hFF) fcount = fcount + 1;
    end
    prev_cs = s_cs; prev_sclk = s_sclk;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); b_addr = a; b_wdata = d; b_wr = 1'b1;
    @(negedge clk); b_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] ds, output logic [31:0] de);
    @(negedge clk); b_addr = a; b_rd = 1'b1;
    @(negedge clk); b_rd = 1'b0; ds = rdata_s; de = rdata_e;
  endtask

  task automatic rd_sel(input logic [4:0] a, output logic [31:0] d);
    logic [31:0] ds, de;
    rd(a, ds, de);
    d = sel ? ds : de;
  endtask

  function automatic int exp_div(input int s, input int code);
    int n, spr, sppr, d;
    if (s == 0) begin
      n = code & 15; if (n < 2) n = 2;
      return 2 * n;
    end
    spr = code & 15; if (spr == 0) spr = 1;
    sppr = (((code >> 6) & 3) << 1) | ((code >> 4) & 1);
    d = spr << sppr; if (d < 2) d = 2;
    return d;
  endfunction

  task automatic run_frame(input int m, input int w, input int code, input int k);
    int cpol, d, lead, f0, csi;
    logic [15:0] data, mask;
    logic [31:0] r;
    string rq;
    rq = sel ? "R7" : "R6";
    cpol = m >> 1; m_cpha = m & 1;
    nbits = w ? 16 : 8;
    mask = w ? 16'hFFFF : 16'h00FF;
    data = 16'(k * 16'h3B5D) ^ 16'hA61C;
    slave_word = {data[7:0], data[15:8]} ^ 16'h5A3C;
    csi = k % 8;
    d = exp_div(sel, code); lead = d - d / 2;
    wr(5'h00, 32'(csi << 2));
    wr(5'h04, 32'((m_cpha << 12) | (cpol << 11) | (w << 5) | code));
    wr(5'h10, 32'h1);
    f0 = fcount;
    wr(5'h08, {16'h0, data});
    rd_sel(5'h00, r);
    chk("R8 busy during frame", r[1], 1);
    if (k % 4 == 0) wr(5'h08, {16'h0, ~data});
    while (fcount == f0) @(negedge clk);
    chk("R3 serial out", cap & mask, data & mask);
    chk("R5 edge count", edges, 2 * nbits);
    chk("R5 rest level", lvl_start, cpol);
    chk("R2 select line", cs_seen, 8'hFF & ~(8'h1 << csi));
    chk("R2 select steady", cs_bad, 0);
    chk({rq, " R11 first edge"}, t_e1 - t_start, lead);
    chk({rq, " R11 period"}, t_e3 - t_e1, d);
    rd_sel(5'h0C, r);
    chk("R4 receive word", r, slave_word & mask);
    rd_sel(5'h10, r);
    chk("R9 cause set", r, 1);
    chk("R9 irq", s_irq, 1);
    rd_sel(5'h00, r);
    chk("R8 busy after", r, 32'(csi << 2));
    if (k % 4 == 0) begin
      rd_sel(5'h08, r);
      chk("R10 tx readback", r, data);
      repeat (2 * d + 4) @(negedge clk);
      chk("R10 no extra frame", fcount, f0 + 1);
      chk("R10 select idle", s_cs, 8'hFF);
    end
  endtask

  initial begin
    logic [31:0] rs, re;
    int codes0 [5] = '{8'h10, 8'h12, 8'h13, 8'h17, 8'h1F};
    int codes1 [5] = '{8'h00, 8'h03, 8'h13, 8'h57, 8'h8B};
    int k = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 reset select", cs_s, 8'hFF);
    chk("R2 reset select even", cs_e, 8'hFF);
    chk("R5 reset sclk", sclk_s, 0);
    rd(5'h00, rs, re);
    chk("R8 reset busy", rs, 0);
    rd(5'h10, rs, re);
    chk("R9 reset cause", rs | re, 0);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, rs, re);
    chk("R1 cfg mask split", rs, 32'h18FF);
    chk("R1 cfg mask even", re, 32'h183F);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, rs, re);
    chk("R1 timing field", rs, 32'hC0);
    chk("R1 timing field even", re, 32'hC0);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, rs, re);
    chk("R1 ctrl index", rs, 32'h1C);
    wr(5'h04, 32'h0);
    repeat (2) @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      sel = s;
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 2; w++)
          for (int c = 0; c < 5; c++) begin
            run_frame(m, w, s ? codes1[c] : codes0[c], k);
            k++;
          end
    end
    // completion status write-one-to-clear (R9)
    wr(5'h10, 32'h0);
    rd_sel(5'h10, rs);
    chk("R9 write zero keeps", rs, 1);
    wr(5'h10, 32'h1);
    rd_sel(5'h10, rs);
    chk("R9 write one clears", rs, 0);
    chk("R9 irq cleared", s_irq, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule